// File: doc/BRIEF.md
# Shared QSPI Flash and PSRAM Memory Controller

This block lets a processor core read and write external memory through one nibble-wide QSPI bus. The bus is shared by three devices. Flash is read-only and is read without a command byte, because it is assumed to already be in continuous-read mode. Two PSRAMs are assumed to already be in QPI mode and are both read and written. The core gives a 28-bit address, a direction and a size. The controller decodes the address into one chip select, serialises the command, address, mode and dummy phases, and moves 1, 2 or 4 data bytes one nibble at a time.

SCK runs at half the system clock. Each SCK period spans two system cycles: the low half first, then the high half. The controller changes its output nibble as SCK falls. It samples incoming nibbles at the end of the high half. It turns the data pins around to inputs before the first dummy clock. Between transactions it keeps every chip select high for at least one full SCK period.

Top module: `qspi_mem_ctrl`

## Requirements
- R1: An address with bits 27:24 equal to 0 selects the flash (CS0, active low). Bits 27:24 equal to 1 with bit 23 clear select RAM A (CS1). Bits 27:24 equal to 1 with bit 23 set select RAM B (CS2). Any other address is dropped: no chip select falls, busy stays low and no data-valid pulse appears.
- R2: Bidirectional pin map, bits 0 to 7: CS0, SD0, SD1, SCK, SD2, SD3, CS1, CS2. The nibble bit i travels on SDi. The output enables of the chip selects and of SCK are always 1.
- R3: A flash read sends no command. It sends address bits 23:0 in 6 clocks, then the mode byte 0xA0 in 2 clocks, then 4 dummy clocks, then 2 clocks per data byte.
- R4: A PSRAM write sends command 0x38 in 2 clocks, then the 24-bit address {0, addr[22:0]} in 6 clocks, then the data with no dummy clocks. A 4-byte write therefore takes 16 SCK clocks. No data-valid pulse follows a write.
- R5: A PSRAM read sends command 0x0B, then the 24-bit address {0, addr[22:0]}, then 4 dummy clocks. This is a 12-clock preamble, so a 4-byte read takes 20 SCK clocks.
- R6: While a chip select is low, SCK toggles on every system cycle. It starts low and the transaction ends with SCK high. SCK is low whenever all chip selects are high.
- R7: A write whose address is in the flash range is dropped. No chip select falls and busy stays low.
- R8: Size code 0 moves 1 byte, code 1 moves 2 bytes, and codes 2 and 3 move 4 bytes. Each byte moves most-significant nibble first. Byte j of the data word (bits 8j+7:8j) moves before byte j+1. Read-data bytes beyond the requested size return as zero.
- R9: During reads, the data-pin output enables are high for exactly the first 8 clocks and low from the first dummy clock onward. During writes they are high for every clock. They are low whenever all chip selects are high.
- R10: Exactly one chip select is low during a transaction. After a chip select rises, all chip selects stay high for at least 2 system cycles.
- R11: A request is taken when req_valid is high and busy is low. Busy is high from the next cycle and falls 2T+2 cycles after acceptance, where T is the SCK clock count. For a read, rdata_valid is high for exactly one cycle, 2T cycles after the accepting edge. A request made while busy is high is ignored.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request strobe, taken when busy is low |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 28 | Byte address |
| req_size | input | 2 | 0: 1 byte, 1: 2 bytes, 2/3: 4 bytes |
| req_wdata | input | 32 | Write data, byte 0 in bits 7:0 |
| busy | output | 1 | Transaction or inter-transaction gap in progress |
| rdata_valid | output | 1 | One-cycle pulse, read data ready |
| rdata | output | 32 | Read data, little-endian, unused bytes zero |
| uio_in | input | 8 | Bus pin inputs |
| uio_out | output | 8 | Bus pin outputs |
| uio_oe | output | 8 | Bus pin output enables |

## Verification
Every result is timed from the accepting clock edge. The bench counts falling edges from that edge. The data-valid pulse must be seen on falling edge 2T+1, and busy must first read low on falling edge 2T+3, where T is the SCK clock count the requirements give for that request. A bus monitor samples at each falling edge of the system clock. It logs the outgoing nibble and its output enable once per SCK high half, and it drives the modelled device's read nibble in that same half, so the nibble is in place for the capture edge that ends the half. Preamble nibbles, enable windows, SCK counts, chip-select identity and inter-transaction gap are all compared after busy falls, against values derived from the address and size.

// File: rtl/qspi_mem_pkg.sv
package qspi_mem_pkg;

    localparam int FRAME_W = 64;
    localparam int CNT_W   = 6;
    localparam int RX_W    = 32;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_XFER,
        ST_GAP
    } seq_st_e;

    typedef enum logic [1:0] {
        DEV_FLASH,
        DEV_RAMA,
        DEV_RAMB,
        DEV_NONE
    } dev_e;

    typedef struct packed {
        seq_st_e            st;
        logic               ph;
        logic [CNT_W-1:0]   cnt;
        logic [CNT_W-1:0]   total;
        logic [CNT_W-1:0]   outclk;
        logic               rd;
        logic [2:0]         cs_n;
        logic               valid;
        logic [FRAME_W-1:0] tx;
        logic [RX_W-1:0]    rx;
    } seq_t;

endpackage

// File: rtl/qspi_addr_map.sv
module qspi_addr_map
    import qspi_mem_pkg::*;
#(
    parameter int ADDR_W = 28,
    parameter int BUS_AW = 24
) (
    input  logic [ADDR_W-1:0] addr,
    output dev_e              dev,
    output logic [2:0]        cs_n,
    output logic [BUS_AW-1:0] bus_addr
);

    localparam int HI_W = ADDR_W - BUS_AW;

    logic [HI_W-1:0] hi;

    always_comb begin
        hi       = addr[ADDR_W-1:BUS_AW];
        dev      = DEV_NONE;
        cs_n     = 3'b111;
        bus_addr = addr[BUS_AW-1:0];
        if (hi == '0) begin
            dev     = DEV_FLASH;
            cs_n[0] = 1'b0;
        end else if (hi == HI_W'(1)) begin
            bus_addr = {1'b0, addr[BUS_AW-2:0]};
            if (addr[BUS_AW-1]) begin
                dev     = DEV_RAMB;
                cs_n[2] = 1'b0;
            end else begin
                dev     = DEV_RAMA;
                cs_n[1] = 1'b0;
            end
        end
    end

endmodule

// File: rtl/qspi_frame_build.sv
module qspi_frame_build
    import qspi_mem_pkg::*;
#(
    parameter int BUS_AW    = 24,
    parameter int RD_PRE    = 12,
    parameter int WR_PRE    = 8,
    parameter int OUT_RD    = 8,
    parameter logic [7:0] FL_MODE = 8'hA0,
    parameter logic [7:0] CMD_WR  = 8'h38,
    parameter logic [7:0] CMD_RD  = 8'h0B
) (
    input  logic               write,
    input  logic               is_flash,
    input  logic [BUS_AW-1:0]  bus_addr,
    input  logic [1:0]         size,
    input  logic [31:0]        wdata,
    output logic [FRAME_W-1:0] tx,
    output logic [CNT_W-1:0]   total,
    output logic [CNT_W-1:0]   outclk
);

    localparam int PAD_W = FRAME_W - 8 - BUS_AW - 32;

    logic [CNT_W-1:0] dclk;
    logic [31:0]      wswap;

    always_comb begin
        case (size)
            2'd0:    dclk = CNT_W'(2);
            2'd1:    dclk = CNT_W'(4);
            default: dclk = CNT_W'(8);
        endcase
        wswap = {wdata[7:0], wdata[15:8], wdata[23:16], wdata[31:24]};
        if (write) begin
            tx     = {CMD_WR, bus_addr, {PAD_W{1'b0}}, wswap};
            total  = CNT_W'(WR_PRE) + dclk;
            outclk = CNT_W'(WR_PRE) + dclk;
        end else begin
            if (is_flash)
                tx = {bus_addr, FL_MODE, {PAD_W{1'b0}}, 32'h0};
            else
                tx = {CMD_RD, bus_addr, {PAD_W{1'b0}}, 32'h0};
            total  = CNT_W'(RD_PRE) + dclk;
            outclk = CNT_W'(OUT_RD);
        end
    end

endmodule

// File: rtl/qspi_mem_ctrl.sv
module qspi_mem_ctrl
    import qspi_mem_pkg::*;
#(
    parameter int ADDR_W = 28,
    parameter int BUS_AW = 24,
    parameter int RD_PRE = 12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic              req_write,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [1:0]        req_size,
    input  logic [31:0]       req_wdata,
    output logic              busy,
    output logic              rdata_valid,
    output logic [31:0]       rdata,
    input  logic [7:0]        uio_in,
    output logic [7:0]        uio_out,
    output logic [7:0]        uio_oe
);

    dev_e               dec_dev;
    logic [2:0]         dec_cs_n;
    logic [BUS_AW-1:0]  dec_baddr;
    logic [FRAME_W-1:0] fr_tx;
    logic [CNT_W-1:0]   fr_total;
    logic [CNT_W-1:0]   fr_outclk;

    qspi_addr_map #(.ADDR_W(ADDR_W), .BUS_AW(BUS_AW)) u_map (
        .addr     (req_addr),
        .dev      (dec_dev),
        .cs_n     (dec_cs_n),
        .bus_addr (dec_baddr)
    );

    qspi_frame_build #(.BUS_AW(BUS_AW), .RD_PRE(RD_PRE)) u_frame (
        .write    (req_write),
        .is_flash (dec_dev == DEV_FLASH),
        .bus_addr (dec_baddr),
        .size     (req_size),
        .wdata    (req_wdata),
        .tx       (fr_tx),
        .total    (fr_total),
        .outclk   (fr_outclk)
    );

    seq_t             s_q, s_d;
    logic [3:0]       nib_in;
    logic [CNT_W-1:0] k;
    logic [4:0]       off;
    logic             start_ok;

    assign nib_in = {uio_in[5], uio_in[4], uio_in[2], uio_in[1]};

    always_comb begin
        s_d      = s_q;
        s_d.valid = 1'b0;
        k        = s_q.cnt - CNT_W'(RD_PRE);
        off      = {k[2:1], ~k[0], 2'b00};
        start_ok = req_valid && (dec_dev != DEV_NONE)
                   && !(req_write && dec_dev == DEV_FLASH);
        case (s_q.st)
            ST_IDLE: begin
                if (start_ok) begin
                    s_d.st     = ST_XFER;
                    s_d.ph     = 1'b0;
                    s_d.cnt    = '0;
                    s_d.tx     = fr_tx;
                    s_d.rx     = '0;
                    s_d.total  = fr_total;
                    s_d.outclk = fr_outclk;
                    s_d.rd     = !req_write;
                    s_d.cs_n   = dec_cs_n;
                end
            end
            ST_XFER: begin
                if (!s_q.ph) begin
                    s_d.ph = 1'b1;
                end else begin
                    s_d.ph = 1'b0;
                    s_d.tx = s_q.tx << 4;
                    if (s_q.rd && s_q.cnt >= CNT_W'(RD_PRE))
                        s_d.rx[off +: 4] = nib_in;
                    if (s_q.cnt == s_q.total - CNT_W'(1)) begin
                        s_d.st    = ST_GAP;
                        s_d.cs_n  = 3'b111;
                        s_d.valid = s_q.rd;
                    end else begin
                        s_d.cnt = s_q.cnt + CNT_W'(1);
                    end
                end
            end
            ST_GAP: begin
                s_d.ph = !s_q.ph;
                if (s_q.ph) s_d.st = ST_IDLE;
            end
            default: s_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q      <= '0;
            s_q.st   <= ST_IDLE;
            s_q.cs_n <= 3'b111;
        end else begin
            s_q <= s_d;
        end
    end

    logic       sck;
    logic       d_oe;
    logic [3:0] nib_out;

    assign sck         = (s_q.st == ST_XFER) && s_q.ph;
    assign d_oe        = (s_q.st == ST_XFER) && (s_q.cnt < s_q.outclk);
    assign nib_out     = s_q.tx[FRAME_W-1 -: 4];
    assign busy        = (s_q.st != ST_IDLE);
    assign rdata_valid = s_q.valid;
    assign rdata       = s_q.rx;
    assign uio_out     = {s_q.cs_n[2], s_q.cs_n[1], nib_out[3], nib_out[2],
                          sck, nib_out[1], nib_out[0], s_q.cs_n[0]};
    assign uio_oe      = {1'b1, 1'b1, d_oe, d_oe, 1'b1, d_oe, d_oe, 1'b1};

    logic [2:0] pin_cs_n;
    logic       cs_act;
    assign pin_cs_n = {uio_out[7], uio_out[6], uio_out[0]};
    assign cs_act   = !(&pin_cs_n);

    AST_ONE_CS: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(~pin_cs_n) <= 1); // R10
    AST_CS_GAP: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(&pin_cs_n) |=> (&pin_cs_n)); // R10
    AST_SCK_TOGGLE: assert property (@(posedge clk) disable iff (!rst_n)
        (cs_act && $past(cs_act)) |-> (uio_out[3] != $past(uio_out[3]))); // R6
    AST_SCK_IDLE_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        (&pin_cs_n) |-> !uio_out[3]); // R6
    AST_DATA_OE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        (&pin_cs_n) |-> (uio_oe[5:4] == 2'b00 && uio_oe[2:1] == 2'b00)); // R9
    AST_VALID_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        rdata_valid |=> !rdata_valid); // R11
    AST_VALID_AFTER_CS: assert property (@(posedge clk) disable iff (!rst_n)
        rdata_valid |-> ((&pin_cs_n) && busy)); // R11

endmodule

// File: tb/tb_qspi_mem_ctrl.sv
module tb_qspi_mem_ctrl;
    timeunit 1ns;
    timeprecision 1ps;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_write = 1'b0;
    logic [27:0] req_addr = '0;
    logic [1:0]  req_size = '0;
    logic [31:0] req_wdata = '0;
    logic        busy, rdata_valid;
    logic [31:0] rdata;
    logic [7:0]  uio_in = '0;
    logic [7:0]  uio_out, uio_oe;

    qspi_mem_ctrl dut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
        .req_addr(req_addr), .req_size(req_size), .req_wdata(req_wdata),
        .busy(busy), .rdata_valid(rdata_valid), .rdata(rdata),
        .uio_in(uio_in), .uio_out(uio_out), .uio_oe(uio_oe)
    );

    always #4 clk = ~clk;

    int checks = 0;
    int fails  = 0;

    task automatic check(input bit ok, input string req, input string what,
                         input longint act, input longint exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
        end
    endtask

    function automatic logic [7:0] devbyte(input logic [23:0] a);
        return (a[7:0] * 8'd13 + 8'h29) ^ a[15:8];
    endfunction

    logic [23:0] dev_base = '0;
    function automatic logic [3:0] devnib(input int k);
        logic [7:0] b;
        b = devbyte(dev_base + 24'(k / 2));
        return (k % 2 == 0) ? b[7:4] : b[3:0];
    endfunction

    // bus monitor and device model
    int         sck_cnt = 0, starts = 0, last_gap = 0, gap_run = 0, ctl_bad = 0;
    logic       act_prev = 1'b0, sck_prev = 1'b0, had_txn = 1'b0;
    logic [2:0] cs_seen = '0;
    logic [3:0] nib_rec [64];
    logic       oe_rec  [64];

    always @(negedge clk) begin
        logic act;
        logic [3:0] dn;
        act = !(uio_out[7] && uio_out[6] && uio_out[0]);
        if (rst_n && !(uio_oe[0] && uio_oe[3] && uio_oe[6] && uio_oe[7])) ctl_bad++;
        if (act && !act_prev) begin
            starts++;
            sck_cnt = 0;
            cs_seen = '0;
            if (had_txn) last_gap = gap_run;
        end
        if (act) begin
            cs_seen = cs_seen | ~{uio_out[7], uio_out[6], uio_out[0]};
            gap_run = 0;
        end else begin
            gap_run++;
        end
        if (act && uio_out[3] && !sck_prev && sck_cnt < 64) begin
            nib_rec[sck_cnt] = {uio_out[5], uio_out[4], uio_out[2], uio_out[1]};
            oe_rec[sck_cnt]  = uio_oe[1];
            if (sck_cnt >= 12) begin
                dn = devnib(sck_cnt - 12);
                uio_in[1] = dn[0];
                uio_in[2] = dn[1];
                uio_in[4] = dn[2];
                uio_in[5] = dn[3];
            end
            sck_cnt++;
        end
        if (!act && act_prev) had_txn = 1'b1;
        act_prev = act;
        sck_prev = uio_out[3];
    end

    function automatic logic [31:0] packn(input int start, input int n);
        logic [31:0] r;
        r = '0;
        for (int i = 0; i < n; i++) r = {r[27:0], nib_rec[start + i]};
        return r;
    endfunction

    function automatic bit oe_ok(input int t, input int outclk);
        for (int c = 0; c < t; c++)
            if (oe_rec[c] !== (c < outclk)) return 1'b0;
        return 1'b0 == 1'b0;
    endfunction

    function automatic int nbytes(input logic [1:0] sz);
        return (sz == 2'd0) ? 1 : (sz == 2'd1) ? 2 : 4;
    endfunction

    function automatic logic [31:0] exp_rd(input logic [23:0] base, input int n);
        logic [31:0] r;
        r = '0;
        for (int j = 0; j < n; j++) r[8*j +: 8] = devbyte(base + 24'(j));
        return r;
    endfunction

    int          v_at, b_at, vcount;
    logic [31:0] got;

    // called at a falling edge; request taken at the next rising edge
    task automatic run_txn(input logic w, input logic [27:0] a, input logic [1:0] sz,
                           input logic [31:0] wd);
        req_valid = 1'b1; req_write = w; req_addr = a; req_size = sz; req_wdata = wd;
        v_at = 0; b_at = 0; vcount = 0; got = '0;
        for (int i = 1; i <= 120; i++) begin
            @(negedge clk);
            if (i == 1) req_valid = 1'b0;
            if (rdata_valid) begin vcount++; v_at = i; got = rdata; end
            if (!busy && b_at == 0) begin b_at = i; break; end
        end
    endtask

    task automatic t_reset();
        check(uio_out[0] && uio_out[6] && uio_out[7], "R10", "cs idle after reset", uio_out, 8'hC1);
        check(!uio_out[3], "R6", "sck low after reset", uio_out[3], 0);
        check(!busy && !rdata_valid, "R11", "busy/valid low after reset", {busy, rdata_valid}, 0);
    endtask

    task automatic t_read(input logic [27:0] a, input logic [1:0] sz, input bit flash,
                          input logic [2:0] exp_cs, input string rq);
        int n, t;
        logic [23:0] ba;
        n  = nbytes(sz);
        t  = 12 + 2 * n;
        ba = flash ? a[23:0] : {1'b0, a[22:0]};
        dev_base = ba;
        run_txn(1'b0, a, sz, 32'h0);
        check(cs_seen == exp_cs, "R1", "chip select", cs_seen, exp_cs);
        check(sck_cnt == t, rq, "sck clock count", sck_cnt, t);
        if (flash)
            check(packn(0, 8) == {ba, 8'hA0}, "R3", "addr+mode nibbles", packn(0, 8), {ba, 8'hA0});
        else
            check(packn(0, 8) == {8'h0B, ba}, "R5", "cmd+addr nibbles", packn(0, 8), {8'h0B, ba});
        check(oe_ok(t, 8), "R9", "read oe window", 0, 1);
        check(vcount == 1 && v_at == 2 * t + 1, "R11", "valid timing", v_at, 2 * t + 1);
        check(b_at == 2 * t + 3, "R11", "busy fall timing", b_at, 2 * t + 3);
        check(got == exp_rd(ba, n), "R8", "read data", got, exp_rd(ba, n));
    endtask

    task automatic t_write(input logic [27:0] a, input logic [1:0] sz, input logic [31:0] wd,
                           input logic [2:0] exp_cs);
        int n, t;
        logic [23:0] ba;
        logic [31:0] sw, ed;
        n  = nbytes(sz);
        t  = 8 + 2 * n;
        ba = {1'b0, a[22:0]};
        sw = {wd[7:0], wd[15:8], wd[23:16], wd[31:24]};
        ed = sw >> (32 - 8 * n);
        run_txn(1'b1, a, sz, wd);
        check(cs_seen == exp_cs, "R1", "write chip select", cs_seen, exp_cs);
        check(sck_cnt == t, "R4", "write sck count", sck_cnt, t);
        check(packn(0, 8) == {8'h38, ba}, "R4", "write cmd+addr", packn(0, 8), {8'h38, ba});
        check(packn(8, 2 * n) == ed, "R8", "write data nibble order", packn(8, 2 * n), ed);
        check(oe_ok(t, t), "R9", "write oe all clocks", 0, 1);
        check(vcount == 0 && b_at == 2 * t + 3, "R4", "write no valid, busy timing", b_at, 2 * t + 3);
    endtask

    task automatic t_drop(input logic w, input logic [27:0] a, input string rq);
        int s0, bsy, vld;
        s0 = starts; bsy = 0; vld = 0;
        req_valid = 1'b1; req_write = w; req_addr = a; req_size = 2'd2; req_wdata = 32'h1234_5678;
        for (int i = 0; i < 12; i++) begin
            @(negedge clk);
            req_valid = 1'b0;
            if (busy) bsy++;
            if (rdata_valid) vld++;
        end
        check(starts == s0 && bsy == 0 && vld == 0, rq, "request dropped", starts - s0 + bsy + vld, 0);
    endtask

    task automatic t_busy_ignore();
        int s0;
        s0 = starts;
        dev_base = 24'h000040;
        req_valid = 1'b1; req_write = 1'b0; req_addr = 28'h0000040; req_size = 2'd2;
        for (int i = 1; i <= 60; i++) begin
            @(negedge clk);
            req_valid = 1'b0;
            if (i == 5) begin
                req_valid = 1'b1; req_write = 1'b1; req_addr = 28'h1000010; req_wdata = 32'hFFFF_FFFF;
            end
            if (!busy && i > 5) break;
        end
        req_valid = 1'b0;
        repeat (8) @(negedge clk);
        check(starts == s0 + 1 && cs_seen == 3'b001, "R11", "request while busy ignored",
              starts - s0, 1);
    endtask

    task automatic t_back_to_back();
        t_read(28'h1000200, 2'd1, 1'b0, 3'b010, "R5");
        t_read(28'h0000300, 2'd0, 1'b1, 3'b001, "R3");
        check(last_gap >= 2, "R10", "chip-select gap", last_gap, 2);
    endtask

    initial begin
        #(8 * 150000);
        fails++;
        checks++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_read(28'h0123456, 2'd2, 1'b1, 3'b001, "R3");
        t_read(28'h0ABCDEF, 2'd0, 1'b1, 3'b001, "R3");
        t_write(28'h1234568, 2'd2, 32'hDEAD_BEEF, 3'b010);
        t_read(28'h1900010, 2'd1, 1'b0, 3'b100, "R5");
        t_read(28'h1800020, 2'd3, 1'b0, 3'b100, "R5");
        t_write(28'h1C00001, 2'd0, 32'h0000_00A5, 3'b100);
        t_write(28'h1000004, 2'd1, 32'h0000_3C96, 3'b010);
        t_drop(1'b1, 28'h0000100, "R7");
        t_drop(1'b0, 28'h2000000, "R1");
        t_busy_ignore();
        t_back_to_back();
        check(ctl_bad == 0, "R2", "cs/sck output enables", ctl_bad, 0);
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

endmodule